// File: doc/BRIEF.md
# Ping-Pong Streaming Matrix Transpose

This block turns a stream of square matrices around: each matrix arrives as one packet in row order, one element per accepted beat, and leaves as one packet in column order. The side of the matrix is a power of two set by a parameter. Elements are written to a RAM at the address row*N + col. A read counter walks the addresses with its two halves swapped, so the elements come out column by column.

Two RAM banks alternate. The bank that receives writes flips each time the write counter wraps past the last element. The read side drains whichever bank holds a complete matrix. This lets matrix k+1 be written while matrix k is read out.

Both edges are valid/ready streams carrying start-of-packet and end-of-packet marks. Back-pressure from the output stalls the reader. When both banks hold unread matrices, the input stops accepting. A two-entry output queue absorbs the one-cycle RAM read latency, so the output can move one element per cycle.

Top module: `stream_transpose`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: With N = 2^DIM_LOG2, the k-th element output for a matrix (k counted from 0) is the input element of that matrix with beat index (k mod N)*N + k/N. Output matrices appear in the order their input matrices were completed.
- R3: `out_sop` is 1 exactly on the first output element of each matrix (element (0,0)). `out_eop` is 1 exactly on the last one (element (N-1,N-1)). For N of at least 2, the two are never 1 on the same beat.
- R4: While the output is fully stalled, two whole matrices (2*N*N beats) are accepted on consecutive cycles with no input stall.
- R5: `in_ready` is 0 whenever both banks hold matrices that are not yet fully read. An element offered in that state is not taken and changes no output.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values. No element is lost or repeated under any `out_ready` pattern.
- R7: An accepted beat with `in_sop` = 1 is stored as element (0,0) and restarts the matrix. A partially written matrix is discarded and never appears at the output. An accepted `in_eop` is expected only on the N*N-th beat of a matrix.
- R8: With `out_ready` held at 1, the elements of one output matrix leave on N*N consecutive cycles, from the `out_sop` beat to the `out_eop` beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block can take an input element |
| in_data | input | DATA_W | Input element, row order |
| in_sop | input | 1 | First element of an input matrix; restarts the write counter |
| in_eop | input | 1 | Last element of an input matrix |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Downstream takes the output element |
| out_data | output | DATA_W | Output element, column order |
| out_sop | output | 1 | First element of an output matrix |
| out_eop | output | 1 | Last element of an output matrix |

## Verification
The bench fills both banks behind a stalled output and then offers more data. A design that flips banks at the wrong count, or keeps `in_ready` high, would overwrite a matrix that has not yet been read, and the drained data would not match. Irregular `out_ready` patterns probe the read-latency queue: a wrong credit count shows up as duplicated or dropped elements, or as `out_data` changing while stalled. A restart in the middle of a packet checks that the abandoned fragment never reaches the output. An unbroken run of N*N beats with `out_ready` high checks that the prefetch keeps full throughput instead of leaving a bubble for each read.

// File: rtl/tp_pkg.sv
package tp_pkg;
   // Swap the low and high halves of an index of 2*half bits.
   function automatic logic [31:0] tp_swap(input logic [31:0] idx, input int unsigned half);
      logic [31:0] lo_mask;
      lo_mask = (32'd1 << half) - 32'd1;
      return ((idx & lo_mask) << half) | ((idx >> half) & lo_mask);
   endfunction

   // Queue entry marks carried beside each element.
   typedef struct packed {
      logic sop;
      logic eop;
   } tp_mark_t;
endpackage

// File: rtl/tp_bank.sv
module tp_bank #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/tp_writer.sv
module tp_writer #(
   parameter int DIM_LOG2 = 2,
   parameter int ADDR_W   = 2 * DIM_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [1:0]        full_i,
   output logic              in_ready,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic              wsel,
   output logic              done
);
   localparam logic [ADDR_W-1:0] LAST = '1;

   logic [ADDR_W-1:0] cnt_q;

   assign in_ready = !full_i[wsel];
   assign we       = in_valid && in_ready;
   assign waddr    = in_sop ? '0 : cnt_q;
   assign done     = we && (waddr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         wsel  <= 1'b0;
      end else if (we) begin
         cnt_q <= waddr + 1'b1;
         if (done) wsel <= ~wsel;
      end
   end

   // R7: an accepted end-of-packet must land on the last element
   p_in_eop_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && in_eop) |-> (waddr == LAST));
endmodule

// File: rtl/tp_reader.sv
module tp_reader
   import tp_pkg::*;
#(
   parameter int DIM_LOG2 = 2,
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2 * DIM_LOG2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             full_i,
   input  logic [1:0][DATA_W-1:0] rdata_i,
   output logic                   re,
   output logic [ADDR_W-1:0]      raddr,
   output logic                   rsel,
   output logic                   release_o,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [DATA_W-1:0]      out_data,
   output logic                   out_sop,
   output logic                   out_eop
);
   localparam logic [ADDR_W-1:0] LAST = '1;
   localparam int ENT_W = DATA_W + 2;

   logic [ADDR_W-1:0] cnt_q;
   logic              infl_q, infl_bank_q;
   tp_mark_t          infl_mark_q;
   logic [ENT_W-1:0]  fifo_q [2];
   logic              wp_q, rp_q;
   logic [1:0]        occ_q;
   logic [1:0]        slots;
   logic              pop, push;

   assign pop       = out_valid && out_ready;
   assign push      = infl_q;
   assign slots     = occ_q + {1'b0, infl_q};
   assign re        = full_i[rsel] && ((slots < 2'd2) || ((slots == 2'd2) && pop));
   assign raddr     = ADDR_W'(tp_swap(32'(cnt_q), DIM_LOG2));
   assign release_o = re && (cnt_q == LAST);

   assign out_valid = (occ_q != 2'd0);
   assign out_sop   = fifo_q[rp_q][ENT_W-1];
   assign out_eop   = fifo_q[rp_q][ENT_W-2];
   assign out_data  = fifo_q[rp_q][DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         rsel        <= 1'b0;
         infl_q      <= 1'b0;
         infl_bank_q <= 1'b0;
         infl_mark_q <= '0;
         wp_q        <= 1'b0;
         rp_q        <= 1'b0;
         occ_q       <= 2'd0;
         fifo_q[0]   <= '0;
         fifo_q[1]   <= '0;
      end else begin
         infl_q <= re;
         if (re) begin
            cnt_q           <= cnt_q + 1'b1;
            infl_bank_q     <= rsel;
            infl_mark_q.sop <= (cnt_q == '0);
            infl_mark_q.eop <= (cnt_q == LAST);
            if (release_o) rsel <= ~rsel;
         end
         if (push) begin
            fifo_q[wp_q] <= {infl_mark_q.sop, infl_mark_q.eop, rdata_i[infl_bank_q]};
            wp_q         <= ~wp_q;
         end
         if (pop) rp_q <= ~rp_q;
         occ_q <= occ_q + {1'b0, push} - {1'b0, pop};
      end
   end

   // R6: the queue never takes an entry it has no room for
   p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (occ_q < 2'd2));

   // R6: a stalled output holds still
   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_sop) && $stable(out_eop)));
endmodule

// File: rtl/stream_transpose.sv
module stream_transpose #(
   parameter int DIM_LOG2 = 2,
   parameter int DATA_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop
);
   localparam int ADDR_W = 2 * DIM_LOG2;

   generate
      if (DIM_LOG2 < 1 || DIM_LOG2 > 6) begin : g_bad_dim
         $error("stream_transpose: DIM_LOG2 must lie in 1..6");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("stream_transpose: DATA_W must be positive");
      end
   endgenerate

   logic [1:0]              full_q;
   logic                    wr_we, wr_sel, wr_done;
   logic [ADDR_W-1:0]       wr_addr;
   logic                    rd_re, rd_sel, rd_release;
   logic [ADDR_W-1:0]       rd_addr;
   logic [1:0][DATA_W-1:0]  bank_rdata;

   tp_writer #(.DIM_LOG2(DIM_LOG2), .ADDR_W(ADDR_W)) u_writer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .full_i(full_q), .in_ready(in_ready), .we(wr_we),
      .waddr(wr_addr), .wsel(wr_sel), .done(wr_done));

   tp_reader #(.DIM_LOG2(DIM_LOG2), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_reader (
      .clk(clk), .rst_n(rst_n), .full_i(full_q), .rdata_i(bank_rdata),
      .re(rd_re), .raddr(rd_addr), .rsel(rd_sel), .release_o(rd_release),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop));

   for (genvar b = 0; b < 2; b++) begin : g_bank
      tp_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
         .clk(clk), .we(wr_we && (wr_sel == 1'(b))), .waddr(wr_addr),
         .wdata(in_data), .re(rd_re && (rd_sel == 1'(b))), .raddr(rd_addr),
         .rdata(bank_rdata[b]));
   end

   // A bank is marked full when its last element is written and freed when
   // its last element is read; the two never hit the same bank in one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 2'b00;
      end else begin
         if (wr_done)    full_q[wr_sel] <= 1'b1;
         if (rd_release) full_q[rd_sel] <= 1'b0;
      end
   end

   // R5: input stalls only when both banks hold unread matrices
   p_ready_low_both_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> (full_q == 2'b11));

   // R3: first and last marks never share a beat
   p_sop_not_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_sop && out_eop));
endmodule

// File: tb/stream_transpose_test.sv
module stream_transpose_test;
   localparam int DL = 2;
   localparam int N  = 1 << DL;
   localparam int NN = N * N;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic out_ready = 1'b0;
   logic in_ready, out_valid, out_sop, out_eop;
   logic [DW-1:0] out_data;

   always #10 clk = ~clk;

   stream_transpose #(.DIM_LOG2(DL), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sop(out_sop), .out_eop(out_eop));

   int errors = 0, checks = 0, cyc = 0;
   int rmode = 3;
   bit span_chk = 1'b0;
   logic [DW-1:0] exp_seed [64];
   int nexp = 0, nrx = 0, k = 0, sop_cyc = 0;
   bit hold_pend = 1'b0;
   logic [DW+1:0] hold_val = '0;

   // Stimulus table: {seed, out_ready mode, input gaps}
   localparam int NV = 5;
   localparam logic [18:0] VEC [NV] = '{
      {16'h0100, 2'd0, 1'b0},
      {16'h2200, 2'd1, 1'b0},
      {16'h4310, 2'd2, 1'b1},
      {16'h7705, 2'd0, 1'b1},
      {16'hA0F0, 2'd1, 1'b1}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Output side: drive out_ready, check each transfer and held beats.
   always @(negedge clk) begin
      if (rst_n) begin
         logic rdy;
         cyc++;
         case (rmode)
            0: rdy = 1'b1;
            1: rdy = cyc[0];
            2: rdy = (cyc % 3) != 0;
            default: rdy = 1'b0;
         endcase
         out_ready = rdy;
         if (hold_pend)
            chk(out_valid && ({out_sop, out_eop, out_data} == hold_val),
                "R6 stalled beat held", int'({out_sop, out_eop, out_data}), int'(hold_val));
         hold_pend = out_valid && !rdy;
         hold_val  = {out_sop, out_eop, out_data};
         if (out_valid && rdy) begin
            logic [DW-1:0] ev;
            ev = exp_seed[nrx] + DW'(3 * ((k % N) * N + k / N));
            chk(nrx < nexp, "R2 no extra matrix", nrx, nexp);
            chk(out_data == ev, "R2 transposed element", int'(out_data), int'(ev));
            chk(out_sop == (k == 0), "R3 out_sop position", int'(out_sop), int'(k == 0));
            chk(out_eop == (k == NN - 1), "R3 out_eop position", int'(out_eop), int'(k == NN - 1));
            if (k == 0) sop_cyc = cyc;
            if (k == NN - 1 && span_chk)
               chk(cyc - sop_cyc == NN - 1, "R8 back-to-back output", cyc - sop_cyc, NN - 1);
            if (k == NN - 1) begin
               k = 0;
               nrx++;
            end else k++;
         end
      end
   end

   // Offer cnt beats; returns the number of cycles spent stalled by in_ready.
   task automatic send_beats(input logic [DW-1:0] seed, input int cnt, input bit gap,
                             output int stalls);
      stalls = 0;
      for (int j = 0; j < cnt; j++) begin
         int g;
         g = 0;
         forever begin
            @(negedge clk);
            if (gap && (g % 3 == 1)) begin
               in_valid = 1'b0;
               g++;
               continue;
            end
            g++;
            in_valid = 1'b1;
            in_data  = seed + DW'(3 * j);
            in_sop   = (j == 0);
            in_eop   = (j == NN - 1);
            #1;
            if (in_ready) break;
            stalls++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
   endtask

   task automatic send_matrix(input logic [DW-1:0] seed, input bit gap, output int stalls);
      exp_seed[nexp] = seed;
      nexp++;
      send_beats(seed, NN, gap, stalls);
   endtask

   task automatic drain();
      while (nrx < nexp) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int st;
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
      chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after release",
          int'({in_ready, out_valid}), 2);

      // Table walk: two matrices per row under each pattern (R2 R3 R6 R8)
      for (int v = 0; v < NV; v++) begin
         rmode    = int'(VEC[v][2:1]);
         span_chk = (VEC[v][2:1] == 2'd0);
         send_matrix(VEC[v][18:3], VEC[v][0], st);
         send_matrix(VEC[v][18:3] ^ 16'h5A5A, VEC[v][0], st);
         drain();
      end
      span_chk = 1'b0;

      // R4 R5: stall the output, fill both banks, then offer more
      rmode = 3;
      repeat (4) @(negedge clk);
      send_matrix(16'h1357, 1'b0, st);
      chk(st == 0, "R4 first matrix no stall", st, 0);
      send_matrix(16'h8642, 1'b0, st);
      chk(st == 0, "R4 second matrix no stall", st, 0);
      #1;
      chk(in_ready == 1'b0, "R5 in_ready low with both banks full", int'(in_ready), 0);
      chk(out_valid && out_sop && out_data == 16'h1357, "R6 first element held",
          int'(out_data), 16'h1357);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = 1'b1;
         in_data  = 16'hDEAD;
         #1;
         chk(in_ready == 1'b0, "R5 extra beat refused", int'(in_ready), 0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      rmode    = 0;
      drain();
      chk(nrx == nexp, "R5 both stored matrices intact", nrx, nexp);

      // R7: a fragment restarted by a new start-of-packet is discarded
      rmode = 2;
      send_beats(16'h0F00, 5, 1'b0, st);
      send_matrix(16'h3C3C, 1'b0, st);
      send_beats(16'h0E00, 9, 1'b1, st);
      send_matrix(16'h6060, 1'b1, st);
      drain();
      chk(nrx == nexp, "R7 only whole matrices emerge", nrx, nexp);
      repeat (5) @(negedge clk);
      chk(out_valid == 1'b0, "R7 fragment produced no output", int'(out_valid), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule